// File: doc/BRIEF.md
# Iterative ChaCha Keystream Core

This core produces one 512-bit ChaCha keystream block at a time and XORs it with a 512-bit data word, yielding a registered 512-bit result and a valid flag. A 256-bit key, a key-length flag, a 64-bit nonce (IV) and a round count (8, 12 or 20) define the stream. The core also keeps a 64-bit block counter internally, as two 32-bit words.

A `start` command (init) clears the block counter and computes block 0. A `more` command (next) advances the counter by one and computes the following block. Each cycle of computation applies four quarter rounds in parallel, alternating column and diagonal passes. A one-bit phase counter and a double-round counter sequence the work. When the rounds are finished, the initial state is added word by word. The sum is serialised little-endian into bytes, with byte 0 in the most significant position, and XORed with the data input.

Top module: `chacha_stream_core`

## Requirements
- R1: After reset, `ready_o` is 1, `data_valid_o` is 0 and `data_o` is all zero.
- R2: An accepted init computes the block with counter 0. State words 0-3 are the constants, words 4-11 are the key, word 12 is the counter low half, word 13 is the counter high half, and words 14-15 are the IV. Key and IV 32-bit slices are read most significant slice first, and each slice is byte-reversed into a word. With an all-zero 128-bit key, a zero IV, 8 rounds and zero data, `data_o[511:448]` is e28a5fa4a67f8c5d and `data_o[35:0]` is 2c816081b.
- R3: An accepted next uses the stored counter plus one. The result differs from the previous block and matches the keystream for that counter.
- R4: `rounds_i` (5 bits) selects 8, 12 or 20 rounds, and it is sampled when a command is accepted.
- R5: With `key_long_i`=1 all 256 key bits are used with the 32-byte constants. With `key_long_i`=0 only `key_i[255:128]` is used, repeated into words 8-11, with the 16-byte constants. The low 128 bits then have no effect.
- R6: `data_o` is the keystream XOR `data_i`, with `data_i` sampled in the cycle that the result is registered.
- R7: After an accepted command, `ready_o` is 0 for exactly `rounds`+1 cycles. `data_valid_o` is 0 during that time and rises together with `ready_o`.
- R8: init or next asserted while `ready_o` is 0 is ignored. It changes neither the block being computed nor the counter.
- R9: When init and next are both asserted while ready, init takes priority and the counter becomes 0.
- R10: `data_o` changes only in the cycle a result is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_i | input | 256 | Key, first key byte in bits 255:248 |
| key_long_i | input | 1 | 1: 256-bit key, 0: 128-bit key in upper half |
| iv_i | input | 64 | Nonce, first byte in bits 63:56 |
| rounds_i | input | 5 | Round count: 8, 12 or 20 |
| init_i | input | 1 | Start at block counter 0 |
| next_i | input | 1 | Advance counter and compute next block |
| data_i | input | 512 | Data to combine with keystream |
| ready_o | output | 1 | Idle and able to accept a command |
| data_o | output | 512 | Registered keystream XOR data |
| data_valid_o | output | 1 | `data_o` holds a completed result |

## Verification
The assertions assume that every accepted command carries a round count of 8, 12 or 20. They also assume that `data_i` carries the intended value in the cycle the result is registered. The bench drives only those three round counts. It holds key, IV, round count and data input fixed from the command until `ready_o` returns, and changes them only while the core is idle. Commands issued while busy are pulsed on purpose, to show that they are ignored.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 16;
  localparam int BLK_W   = WORD_W * N_WORDS;
  localparam int LANES   = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [N_WORDS-1:0] state_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  localparam word_t SIGMA0  = 32'h61707865;
  localparam word_t SIGMA1L = 32'h3320646e;
  localparam word_t SIGMA1S = 32'h3120646e;
  localparam word_t SIGMA2L = 32'h79622d32;
  localparam word_t SIGMA2S = 32'h79622d36;
  localparam word_t SIGMA3  = 32'h6b206574;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t bswap(input word_t x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic quad_t qround(input quad_t q);
    quad_t r;
    r = q;
    r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 16);
    r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 12);
    r.a = r.a + r.b; r.d = rotl(r.d ^ r.a, 8);
    r.c = r.c + r.d; r.b = rotl(r.b ^ r.c, 7);
    return r;
  endfunction
endpackage

// File: rtl/chacha_qround.sv
module chacha_qround
  import chacha_pkg::*;
(
  input  quad_t q_i,
  output quad_t q_o
);
  assign q_o = qround(q_i);
endmodule

// File: rtl/chacha_seed.sv
module chacha_seed
  import chacha_pkg::*;
(
  input  logic [255:0] key_i,
  input  logic         key_long_i,
  input  logic [63:0]  iv_i,
  input  logic [63:0]  ctr_i,
  output state_t       seed_o
);
  always_comb begin
    seed_o[0] = SIGMA0;
    seed_o[1] = key_long_i ? SIGMA1L : SIGMA1S;
    seed_o[2] = key_long_i ? SIGMA2L : SIGMA2S;
    seed_o[3] = SIGMA3;
    for (int j = 0; j < 4; j++) begin
      seed_o[4+j] = bswap(key_i[255-32*j -: 32]);
      seed_o[8+j] = key_long_i ? bswap(key_i[127-32*j -: 32])
                               : bswap(key_i[255-32*j -: 32]);
    end
    seed_o[12] = ctr_i[31:0];
    seed_o[13] = ctr_i[63:32];
    seed_o[14] = bswap(iv_i[63:32]);
    seed_o[15] = bswap(iv_i[31:0]);
  end
endmodule

// File: rtl/chacha_half_round.sv
module chacha_half_round
  import chacha_pkg::*;
(
  input  state_t st_i,
  input  logic   diag_i,
  output state_t st_o
);
  quad_t lane_in  [LANES];
  quad_t lane_out [LANES];

  function automatic int idx(input int g, input int row, input logic diag);
    return diag ? (4*row + ((g + row) % 4)) : (4*row + g);
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      lane_in[g].a = st_i[idx(g, 0, diag_i)];
      lane_in[g].b = st_i[idx(g, 1, diag_i)];
      lane_in[g].c = st_i[idx(g, 2, diag_i)];
      lane_in[g].d = st_i[idx(g, 3, diag_i)];
    end
    chacha_qround u_qr (.q_i(lane_in[g]), .q_o(lane_out[g]));
  end

  always_comb begin
    st_o = st_i;
    for (int g = 0; g < LANES; g++) begin
      st_o[idx(g, 0, diag_i)] = lane_out[g].a;
      st_o[idx(g, 1, diag_i)] = lane_out[g].b;
      st_o[idx(g, 2, diag_i)] = lane_out[g].c;
      st_o[idx(g, 3, diag_i)] = lane_out[g].d;
    end
  end
endmodule

// File: rtl/chacha_stream_core.sv
module chacha_stream_core
  import chacha_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [255:0] key_i,
  input  logic         key_long_i,
  input  logic [63:0]  iv_i,
  input  logic [4:0]   rounds_i,
  input  logic         init_i,
  input  logic         next_i,
  input  logic [511:0] data_i,
  output logic         ready_o,
  output logic [511:0] data_o,
  output logic         data_valid_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ROUND, ST_FINAL} fsm_t;

  fsm_t        fsm_q;
  state_t      work_q, seed_q, seed_d, step_d;
  logic        phase_q;
  logic [3:0]  dr_q, dr_last_q;
  logic [31:0] ctr_lo_q, ctr_hi_q;
  logic [63:0] ctr_sel;

  wire cmd_take   = (fsm_q == ST_IDLE) && (init_i || next_i);
  wire round_done = (fsm_q == ST_ROUND) && phase_q && (dr_q == dr_last_q);
  wire emit       = (fsm_q == ST_FINAL);

  assign ctr_sel = init_i ? 64'd0 : ({ctr_hi_q, ctr_lo_q} + 64'd1);

  chacha_seed u_seed (
    .key_i(key_i), .key_long_i(key_long_i), .iv_i(iv_i),
    .ctr_i(ctr_sel), .seed_o(seed_d)
  );

  chacha_half_round u_step (.st_i(work_q), .diag_i(phase_q), .st_o(step_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q     <= ST_IDLE;
      work_q    <= '0;
      seed_q    <= '0;
      phase_q   <= 1'b0;
      dr_q      <= '0;
      dr_last_q <= '0;
      ctr_lo_q  <= '0;
      ctr_hi_q  <= '0;
    end else begin
      case (fsm_q)
        ST_IDLE: if (cmd_take) begin
          work_q    <= seed_d;
          seed_q    <= seed_d;
          ctr_lo_q  <= ctr_sel[31:0];
          ctr_hi_q  <= ctr_sel[63:32];
          dr_last_q <= rounds_i[4:1] - 4'd1;
          phase_q   <= 1'b0;
          dr_q      <= '0;
          fsm_q     <= ST_ROUND;
        end
        ST_ROUND: begin
          work_q  <= step_d;
          phase_q <= ~phase_q;
          if (phase_q) dr_q <= dr_q + 4'd1;
          if (round_done) fsm_q <= ST_FINAL;
        end
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_o      <= 1'b1;
      data_valid_o <= 1'b0;
      data_o       <= '0;
    end else if (cmd_take) begin
      ready_o      <= 1'b0;
      data_valid_o <= 1'b0;
    end else if (emit) begin
      ready_o      <= 1'b1;
      data_valid_o <= 1'b1;
      for (int i = 0; i < N_WORDS; i++)
        data_o[BLK_W-1-WORD_W*i -: WORD_W] <=
          bswap(work_q[i] + seed_q[i]) ^ data_i[BLK_W-1-WORD_W*i -: WORD_W];
    end
  end

  AST_ROUNDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |-> (rounds_i == 5'd8 || rounds_i == 5'd12 || rounds_i == 5'd20)); // R4
  AST_CTR_ZERO_ON_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && init_i) |=> ({ctr_hi_q, ctr_lo_q} == 64'd0)); // R9
  AST_CTR_STEP_ON_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && !init_i) |=> ({ctr_hi_q, ctr_lo_q} == $past({ctr_hi_q, ctr_lo_q}) + 64'd1)); // R3
  AST_CTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_take |=> $stable({ctr_hi_q, ctr_lo_q})); // R8
  AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> (!ready_o && !data_valid_o)); // R7
  AST_VALID_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> ready_o); // R7
  AST_OUT_ONLY_ON_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> $stable(data_o)); // R10
  AST_FINISH_RAISES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |=> ##1 (ready_o && data_valid_o)); // R7
endmodule

// File: tb/chacha_stream_core_tb.sv
`timescale 1ns/1ps
module chacha_stream_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] key = '0;
  logic         klong = 1'b0;
  logic [63:0]  iv = '0;
  logic [4:0]   nr = 5'd8;
  logic         init = 1'b0, nxt = 1'b0;
  logic [511:0] din = '0;
  logic         ready, valid;
  logic [511:0] dout;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chacha_stream_core u_dut (
    .clk(clk), .rst_n(rst_n), .key_i(key), .key_long_i(klong), .iv_i(iv),
    .rounds_i(nr), .init_i(init), .next_i(nxt), .data_i(din),
    .ready_o(ready), .data_o(dout), .data_valid_o(valid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected fewer)", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---- independent reference model ----
  function automatic logic [31:0] rl(input logic [31:0] v, input int s);
    return (v << s) | (v >> (32 - s));
  endfunction
  function automatic logic [31:0] le(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = v[31-8*b -: 8];
    return r;
  endfunction
  function automatic logic [511:0] model(input logic [255:0] k, input logic kl,
      input logic [63:0] n, input logic [63:0] ctr, input int rounds,
      input logic [511:0] d);
    logic [31:0] s[16], w[16];
    int q[4];
    logic [511:0] r;
    s[0] = "expa" == 32'h65787061 ? 32'h61707865 : 32'h0;
    s[1] = kl ? 32'h3320646e : 32'h3120646e;
    s[2] = kl ? 32'h79622d32 : 32'h79622d36;
    s[3] = 32'h6b206574;
    for (int j = 0; j < 8; j++)
      s[4+j] = le((kl || j < 4) ? k[255-32*j -: 32] : k[255-32*(j-4) -: 32]);
    s[12] = ctr[31:0]; s[13] = ctr[63:32];
    s[14] = le(n[63:32]); s[15] = le(n[31:0]);
    w = s;
    for (int rd = 0; rd < rounds; rd++)
      for (int g = 0; g < 4; g++) begin
        for (int row = 0; row < 4; row++)
          q[row] = 4*row + ((rd % 2 == 1) ? ((g + row) % 4) : g);
        w[q[0]] += w[q[1]]; w[q[3]] = rl(w[q[3]] ^ w[q[0]], 16);
        w[q[2]] += w[q[3]]; w[q[1]] = rl(w[q[1]] ^ w[q[2]], 12);
        w[q[0]] += w[q[1]]; w[q[3]] = rl(w[q[3]] ^ w[q[0]], 8);
        w[q[2]] += w[q[3]]; w[q[1]] = rl(w[q[1]] ^ w[q[2]], 7);
      end
    for (int i = 0; i < 16; i++) r[511-32*i -: 32] = le(w[i] + s[i]) ^ d[511-32*i -: 32];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [511:0] got, input logic [511:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // issue a command and wait for completion; returns busy cycle count
  task automatic run(input logic i_init, input logic i_next, output int busy);
    @(negedge clk); init = i_init; nxt = i_next;
    @(negedge clk); init = 1'b0; nxt = 1'b0;
    busy = 0;
    while (!ready) begin busy++; @(negedge clk); end
  endtask

  task automatic t_reset;
    chk("R1 ready", {511'd0, ready}, 512'd1);
    chk("R1 valid", {511'd0, valid}, 512'd0);
    chk("R1 data", dout, 512'd0);
  endtask

  task automatic t_known;
    int b;
    key = '0; klong = 0; iv = '0; nr = 8; din = '0;
    run(1, 0, b);
    chk("R2 prefix", {448'd0, dout[511:448]}, {448'd0, 64'he28a5fa4a67f8c5d});
    chk("R2 suffix", {476'd0, dout[35:0]}, {476'd0, 36'h2c816081b});
    chk("R2 model", dout, model(key, 0, iv, 0, 8, din));
    chk("R7 latency 8", b, 9);
    chk("R7 valid", {511'd0, valid}, 512'd1);
  endtask

  task automatic t_long_next;
    int b;
    logic [511:0] first;
    key = 256'h00112233445566778899aabbccddeeffffeeddccbbaa99887766554433221100;
    klong = 1; iv = 64'h0f1e2d3c4b596877; nr = 12;
    din = {16{32'hdeadbeef}};
    run(1, 0, b);
    chk("R5 R6 256-bit 12 rounds", dout, model(key, 1, iv, 0, 12, din));
    chk("R4 latency 12", b, 13);
    first = dout;
    run(0, 1, b);
    chk("R3 second block", dout, model(key, 1, iv, 1, 12, din));
    n_vec++;
    if (dout === first) begin n_bad++; $display("FAIL R3: actual %h expected a different block", dout); end
    run(0, 1, b);
    chk("R3 third block", dout, model(key, 1, iv, 2, 12, din));
  endtask

  task automatic t_twenty;
    int b;
    nr = 20; klong = 1; din = '0;
    run(1, 0, b);
    chk("R4 20 rounds", dout, model(key, 1, iv, 0, 20, din));
    chk("R4 latency 20", b, 21);
  endtask

  task automatic t_short_key;
    int b;
    logic [511:0] a;
    klong = 0; nr = 8; din = '0;
    key = {128'h0123456789abcdeffedcba9876543210, 128'd0};
    run(1, 0, a[0] ? b : b);
    a = dout;
    key[127:0] = 128'hffffffff_12345678_aaaaaaaa_55555555;
    run(1, 0, b);
    chk("R5 low key ignored", dout, a);
    chk("R5 128-bit model", dout, model(key, 0, iv, 0, 8, din));
  endtask

  task automatic t_busy_ignore;
    int b;
    klong = 1; nr = 8; din = {8{64'h0123456789abcdef}};
    run(1, 0, b);
    @(negedge clk); nxt = 1;
    @(negedge clk); nxt = 0;
    chk("R7 valid low while busy", {510'd0, valid, ready}, 512'd0);
    repeat (2) @(negedge clk);
    init = 1; @(negedge clk); init = 0; nxt = 1; @(negedge clk); nxt = 0;
    while (!ready) @(negedge clk);
    chk("R8 busy cmds ignored", dout, model(key, 1, iv, 1, 8, din));
    run(0, 1, b);
    chk("R8 counter kept", dout, model(key, 1, iv, 2, 8, din));
  endtask

  task automatic t_priority;
    int b;
    run(1, 1, b);
    chk("R9 init wins", dout, model(key, 1, iv, 0, 8, din));
  endtask

  task automatic t_data_sample;
    int b;
    logic [511:0] hold;
    hold = dout;
    din = {16{32'h5a5a5a5a}};
    @(negedge clk); nxt = 1; @(negedge clk); nxt = 0;
    @(negedge clk);
    chk("R10 data held while busy", dout, hold);
    din = {16{32'h0f0f0f0f}};
    while (!ready) @(negedge clk);
    chk("R6 data at finish", dout, model(key, 1, iv, 1, 8, {16{32'h0f0f0f0f}}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_known;
    t_long_next;
    t_twenty;
    t_short_key;
    t_busy_ignore;
    t_priority;
    t_data_sample;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule